// File: doc/BRIEF.md
# Thermal Trip Clock Throttler

This block watches a digital die-temperature reading and applies two levels of protection. When the reading reaches a calibrated throttle level, it drives the core clock enable through a repeating pattern of enabled and stalled cycles, which lowers the average switching rate. When the reading reaches a higher critical level, it raises a shutdown request. That request stays asserted until the block is reset.

Throttling has two possible causes: the block's own temperature comparison, or a software request pin. Either one is enough on its own. The hardware comparison is the fail-safe path, and it engages one clock after the crossing sample, whatever software does. A hysteresis margin keeps a reading that sits on the trip level from toggling the throttle on and off. A small write port sets the trip levels, the hysteresis and the lengths of the enabled and stalled phases. Phase lengths are counted in cycles of the block clock, so at 250 MHz a length of 500 gives 2 µs.

Top module: `thermal_throttle`

## Requirements
- R1: Synchronous reset gives the following state. `clk_en_o` is 1, `throttling_o` is 0 and `shutdown_o` is 0. The settings take their default parameter values (throttle level DEF_TRIP, critical level DEF_CRIT, margin DEF_HYST, phase lengths DEF_ON and DEF_OFF).
- R2: If `temp_i` is greater than or equal to the throttle level when sampled at a clock edge, `throttling_o` is 1 after that edge.
- R3: The hardware cause of throttling stays active while `temp_i` is at or above the throttle level minus the margin. It clears at the first edge that samples a lower value. The subtraction saturates at zero, so a margin larger than the level keeps the hardware cause active until reset.
- R4: If `sw_throttle_i` is sampled at 1 at an edge, `throttling_o` is 1 after that edge, whatever the temperature. `throttling_o` is the OR of the software request and the hardware cause.
- R5: While `throttling_o` is 0, `clk_en_o` is 1 after the next edge.
- R6: Once throttling engages, `clk_en_o` follows a fixed pattern, starting one cycle after `throttling_o` rises: ON cycles at 1, then OFF cycles at 0, repeating. The pattern always starts with a fresh enabled phase, and a programmed length of 0 behaves as 1.
- R7: If `temp_i` is greater than or equal to the critical level when sampled at an edge, `shutdown_o` is 1 after that edge. It then stays at 1 until reset.
- R8: A write with `cfg_we_i` = 1 updates a setting at the clock edge. The address selects it: 0 = throttle level, 1 = critical level, 2 = margin, 3 = ON length, 4 = OFF length. Temperature settings take the low TEMP_W bits of the data and lengths take the low CNT_W bits. Addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and phase timebase |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | TEMP_W | Unsigned temperature sample |
| sw_throttle_i | input | 1 | Software throttle request |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_addr_i | input | 3 | Setting select |
| cfg_data_i | input | CFG_W | Setting write data |
| clk_en_o | output | 1 | Registered core clock enable |
| throttling_o | output | 1 | Registered throttle-active status |
| shutdown_o | output | 1 | Latched critical shutdown request |

## Verification
The assertions assume that `temp_i` and `sw_throttle_i` hold steady between edges, and that the settings they read are stable across the compared edge. The bench meets this by driving every input at the falling clock edge. The phase pattern check in R6 assumes the phase lengths do not change while throttling is active, so the bench writes lengths only when the temperature is low and the software request is clear. The bench's behavioural model predicts all three outputs on every cycle, including the saturated-margin case and writes to unused addresses.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

  typedef enum logic [2:0] {
    CFG_TRIP = 3'd0,
    CFG_CRIT = 3'd1,
    CFG_HYST = 3'd2,
    CFG_ON   = 3'd3,
    CFG_OFF  = 3'd4
  } cfg_addr_e;

  typedef enum logic {
    PH_RUN   = 1'b0,
    PH_STALL = 1'b1
  } phase_e;

endpackage

// File: rtl/thermal_cfg_regs.sv
module thermal_cfg_regs
  import thermal_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int CNT_W    = 12,
  parameter int CFG_W    = 12,
  parameter int DEF_TRIP = 85,
  parameter int DEF_CRIT = 100,
  parameter int DEF_HYST = 3,
  parameter int DEF_ON   = 500,
  parameter int DEF_OFF  = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [CFG_W-1:0]  data,
  output logic [TEMP_W-1:0] trip_q,
  output logic [TEMP_W-1:0] crit_q,
  output logic [TEMP_W-1:0] hyst_q,
  output logic [CNT_W-1:0]  on_len_q,
  output logic [CNT_W-1:0]  off_len_q
);

  logic [TEMP_W-1:0] data_t;
  logic [CNT_W-1:0]  data_c;

  assign data_t = data[TEMP_W-1:0];
  assign data_c = data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_q    <= TEMP_W'(DEF_TRIP);
      crit_q    <= TEMP_W'(DEF_CRIT);
      hyst_q    <= TEMP_W'(DEF_HYST);
      on_len_q  <= CNT_W'(DEF_ON);
      off_len_q <= CNT_W'(DEF_OFF);
    end else if (we) begin
      case (addr)
        CFG_TRIP: trip_q    <= data_t;
        CFG_CRIT: crit_q    <= data_t;
        CFG_HYST: hyst_q    <= data_t;
        CFG_ON:   on_len_q  <= data_c;
        CFG_OFF:  off_len_q <= data_c;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/thermal_trip_detect.sv
module thermal_trip_detect #(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp,
  input  logic              sw_req,
  input  logic [TEMP_W-1:0] trip,
  input  logic [TEMP_W-1:0] crit,
  input  logic [TEMP_W-1:0] hyst,
  output logic              active_q,
  output logic              shut_q
);

  logic              hot_q;
  logic              hot_d;
  logic [TEMP_W-1:0] release_lvl;
  logic              at_trip;
  logic              below_release;

  always_comb begin
    release_lvl   = (trip > hyst) ? (trip - hyst) : '0;
    at_trip       = (temp >= trip);
    below_release = (temp < release_lvl);
    if (at_trip)            hot_d = 1'b1;
    else if (below_release) hot_d = 1'b0;
    else                    hot_d = hot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_q    <= 1'b0;
      active_q <= 1'b0;
      shut_q   <= 1'b0;
    end else begin
      hot_q    <= hot_d;
      active_q <= hot_d | sw_req;
      shut_q   <= shut_q | (temp >= crit);
    end
  end

endmodule

// File: rtl/thermal_duty_gen.sv
module thermal_duty_gen
  import thermal_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [CNT_W-1:0] on_len,
  input  logic [CNT_W-1:0] off_len,
  output logic             clk_en_q
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_d_q;
  logic             run_done;
  logic             stall_done;

  assign run_done   = (cnt_q >= on_len);
  assign stall_done = (cnt_q >= off_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_RUN;
      cnt_q      <= '0;
      active_d_q <= 1'b0;
      clk_en_q   <= 1'b1;
    end else begin
      active_d_q <= active;
      if (!active) begin
        phase_q  <= PH_RUN;
        cnt_q    <= '0;
        clk_en_q <= 1'b1;
      end else if (!active_d_q) begin
        phase_q  <= PH_RUN;
        cnt_q    <= CNT_W'(1);
        clk_en_q <= 1'b1;
      end else if (phase_q == PH_RUN) begin
        if (run_done) begin
          phase_q  <= PH_STALL;
          cnt_q    <= CNT_W'(1);
          clk_en_q <= 1'b0;
        end else begin
          cnt_q    <= cnt_q + CNT_W'(1);
          clk_en_q <= 1'b1;
        end
      end else begin
        if (stall_done) begin
          phase_q  <= PH_RUN;
          cnt_q    <= CNT_W'(1);
          clk_en_q <= 1'b1;
        end else begin
          cnt_q    <= cnt_q + CNT_W'(1);
          clk_en_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle #(
  parameter int TEMP_W   = 8,
  parameter int CNT_W    = 12,
  parameter int DEF_TRIP = 85,
  parameter int DEF_CRIT = 100,
  parameter int DEF_HYST = 3,
  parameter int DEF_ON   = 500,
  parameter int DEF_OFF  = 500,
  localparam int CFG_W   = (TEMP_W > CNT_W) ? TEMP_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              sw_throttle_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  output logic              clk_en_o,
  output logic              throttling_o,
  output logic              shutdown_o
);

  logic [TEMP_W-1:0] trip_q;
  logic [TEMP_W-1:0] crit_q;
  logic [TEMP_W-1:0] hyst_q;
  logic [CNT_W-1:0]  on_len_q;
  logic [CNT_W-1:0]  off_len_q;

  thermal_cfg_regs #(
    .TEMP_W(TEMP_W), .CNT_W(CNT_W), .CFG_W(CFG_W),
    .DEF_TRIP(DEF_TRIP), .DEF_CRIT(DEF_CRIT), .DEF_HYST(DEF_HYST),
    .DEF_ON(DEF_ON), .DEF_OFF(DEF_OFF)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .we(cfg_we_i), .addr(cfg_addr_i), .data(cfg_data_i),
    .trip_q(trip_q), .crit_q(crit_q), .hyst_q(hyst_q),
    .on_len_q(on_len_q), .off_len_q(off_len_q)
  );

  thermal_trip_detect #(.TEMP_W(TEMP_W)) u_trip (
    .clk(clk), .rst(rst),
    .temp(temp_i), .sw_req(sw_throttle_i),
    .trip(trip_q), .crit(crit_q), .hyst(hyst_q),
    .active_q(throttling_o), .shut_q(shutdown_o)
  );

  thermal_duty_gen #(.CNT_W(CNT_W)) u_duty (
    .clk(clk), .rst(rst),
    .active(throttling_o),
    .on_len(on_len_q), .off_len(off_len_q),
    .clk_en_q(clk_en_o)
  );

endmodule

// File: rtl/thermal_throttle_chk.sv
module thermal_throttle_chk #(
  parameter int TEMP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [TEMP_W-1:0] temp_i,
  input logic              sw_throttle_i,
  input logic [TEMP_W-1:0] trip_q,
  input logic [TEMP_W-1:0] crit_q,
  input logic              clk_en_o,
  input logic              throttling_o,
  input logic              shutdown_o
);

  a_r1_reset_state: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (clk_en_o && !throttling_o && !shutdown_o));

  a_r2_trip_engages: assert property (@(posedge clk) disable iff (rst)
    (temp_i >= trip_q) |=> throttling_o);

  a_r4_sw_engages: assert property (@(posedge clk) disable iff (rst)
    sw_throttle_i |=> throttling_o);

  a_r5_full_speed: assert property (@(posedge clk) disable iff (rst)
    !throttling_o |=> clk_en_o);

  a_r6_stall_needs_throttle: assert property (@(posedge clk) disable iff (rst)
    !clk_en_o |-> $past(throttling_o));

  a_r7_crit_fires: assert property (@(posedge clk) disable iff (rst)
    (temp_i >= crit_q) |=> shutdown_o);

  a_r7_shutdown_sticky: assert property (@(posedge clk) disable iff (rst)
    shutdown_o |=> shutdown_o);

endmodule

bind thermal_throttle thermal_throttle_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rst(rst), .temp_i(temp_i), .sw_throttle_i(sw_throttle_i),
  .trip_q(trip_q), .crit_q(crit_q), .clk_en_o(clk_en_o),
  .throttling_o(throttling_o), .shutdown_o(shutdown_o)
);

// File: tb/thermal_throttle_tb.sv
module thermal_throttle_tb;

  localparam int TEMP_W = 8;
  localparam int CNT_W  = 12;
  localparam int CFG_W  = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [TEMP_W-1:0] temp_i = '0;
  logic              sw_throttle_i = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [2:0]        cfg_addr_i = '0;
  logic [CFG_W-1:0]  cfg_data_i = '0;
  logic              clk_en_o, throttling_o, shutdown_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thermal_throttle u_dut (
    .clk(clk), .rst(rst), .temp_i(temp_i), .sw_throttle_i(sw_throttle_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i),
    .clk_en_o(clk_en_o), .throttling_o(throttling_o), .shutdown_o(shutdown_o)
  );

  // Behavioural reference model
  int m_trip, m_crit, m_hyst, m_on, m_off, m_pos;
  bit m_hot, m_thr, m_thr_d, m_en, m_shut;

  always @(posedge clk) begin
    int low, on_e, off_e, t;
    bit n_hot, n_thr, n_en, n_shut;
    t = int'(temp_i);
    if (rst) begin
      m_trip = 85; m_crit = 100; m_hyst = 3; m_on = 500; m_off = 500;
      m_hot = 0; m_thr = 0; m_thr_d = 0; m_en = 1; m_shut = 0; m_pos = 0;
    end else begin
      low   = (m_trip > m_hyst) ? m_trip - m_hyst : 0;
      n_hot = (t >= m_trip) ? 1'b1 : ((t < low) ? 1'b0 : m_hot);
      n_thr = n_hot | sw_throttle_i;
      on_e  = (m_on  < 1) ? 1 : m_on;
      off_e = (m_off < 1) ? 1 : m_off;
      if (!m_thr) begin
        n_en = 1; m_pos = 0;
      end else if (!m_thr_d) begin
        n_en = 1; m_pos = 0;
      end else begin
        m_pos = m_pos + 1;
        n_en = ((m_pos % (on_e + off_e)) < on_e);
      end
      n_shut = m_shut | (t >= m_crit);
      m_thr_d = m_thr;
      m_hot = n_hot; m_thr = n_thr; m_en = n_en; m_shut = n_shut;
      if (cfg_we_i) begin
        case (cfg_addr_i)
          3'd0: m_trip = int'(cfg_data_i[TEMP_W-1:0]);
          3'd1: m_crit = int'(cfg_data_i[TEMP_W-1:0]);
          3'd2: m_hyst = int'(cfg_data_i[TEMP_W-1:0]);
          3'd3: m_on   = int'(cfg_data_i[CNT_W-1:0]);
          3'd4: m_off  = int'(cfg_data_i[CNT_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      chk("R5/R6 clk_en", clk_en_o, m_en);
      chk("R2/R3/R4 throttling", throttling_o, m_thr);
      chk("R7 shutdown", shutdown_o, m_shut);
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_data_i = CFG_W'(d);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    // R1 reset state
    chk("R1 clk_en", clk_en_o, 1'b1);
    chk("R1 throttling", throttling_o, 1'b0);
    chk("R1 shutdown", shutdown_o, 1'b0);
    rst = 1'b0;
    temp_i = 8'd25;
    wait_cyc(3);
    // R8 program short phases
    wr(3'd3, 3);
    wr(3'd4, 2);
    // R1 default throttle level: 84 does not engage, 85 does
    temp_i = 8'd84; wait_cyc(3);
    chk("R1 default trip below", throttling_o, 1'b0);
    temp_i = 8'd85; wait_cyc(1);
    chk("R2 engages at trip", throttling_o, 1'b1);
    wait_cyc(20);
    // R3 hysteresis window 82..84 holds
    temp_i = 8'd82; wait_cyc(5);
    chk("R3 holds in margin", throttling_o, 1'b1);
    temp_i = 8'd81; wait_cyc(1);
    chk("R3 releases below margin", throttling_o, 1'b0);
    wait_cyc(2);
    chk("R5 enable back on", clk_en_o, 1'b1);
    // R4 software request alone
    temp_i = 8'd20; sw_throttle_i = 1'b1; wait_cyc(1);
    chk("R4 sw engages", throttling_o, 1'b1);
    wait_cyc(17);
    sw_throttle_i = 1'b0; wait_cyc(3);
    // R6 zero lengths act as one
    wr(3'd3, 0);
    wr(3'd4, 0);
    sw_throttle_i = 1'b1; wait_cyc(3);
    chk("R6 len0 stall phase", clk_en_o, 1'b0);
    wait_cyc(1);
    chk("R6 len0 run phase", clk_en_o, 1'b1);
    wait_cyc(8);
    // R4 both causes together, hw released while sw holds
    temp_i = 8'd90; wait_cyc(4); temp_i = 8'd10; wait_cyc(4);
    chk("R4 sw keeps throttle", throttling_o, 1'b1);
    sw_throttle_i = 1'b0; wait_cyc(3);
    wr(3'd3, 4);
    wr(3'd4, 3);
    // R8 unused address ignored
    wr(3'd7, 20);
    wr(3'd5, 20);
    temp_i = 8'd30; wait_cyc(3);
    chk("R8 unused addr ignored", throttling_o, 1'b0);
    // R8 retarget throttle level
    wr(3'd0, 50);
    temp_i = 8'd55; wait_cyc(1);
    chk("R8 new trip engages", throttling_o, 1'b1);
    wait_cyc(20);
    temp_i = 8'd40; wait_cyc(2);
    chk("R8 new trip releases", throttling_o, 1'b0);
    // R3 saturated margin never releases
    wr(3'd2, 60);
    temp_i = 8'd50; wait_cyc(2);
    temp_i = 8'd0; wait_cyc(10);
    chk("R3 saturated margin holds", throttling_o, 1'b1);
    // R7 critical shutdown latches (upper data bits dropped: 0x164 -> 100)
    wr(3'd1, 12'h164);
    temp_i = 8'd99; wait_cyc(2);
    chk("R7 below crit", shutdown_o, 1'b0);
    temp_i = 8'd100; wait_cyc(1);
    chk("R7 shutdown at crit", shutdown_o, 1'b1);
    temp_i = 8'd20; wait_cyc(6);
    chk("R7 shutdown sticky", shutdown_o, 1'b1);
    // R1 reset clears everything
    rst = 1'b1; wait_cyc(2);
    chk("R1 reset clears shutdown", shutdown_o, 1'b0);
    chk("R1 reset clears throttle", throttling_o, 1'b0);
    rst = 1'b0; wait_cyc(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule